// File: doc/BRIEF.md
# Interrupt and Reset Sequencer

This block sits beside an 8-bit CPU core and is consulted at every instruction boundary. When the core raises `bnd_req`, the sequencer chooses one event: a pending reset, a one-boundary-late NMI, a normal NMI, or a maskable interrupt. It then runs the bus sequence that event needs and hands the core new register values. An interrupt pushes the return state onto the stack page and fetches a vector. A reset fetches its vector without pushing anything. The core's fetch stage stays stalled until `done`.

Pending sources are held inside the block. Reset is pending after power-up and again after each `rst_req_set`. NMI and late-NMI are set by strobes. The maskable sources are a small mask with a set strobe and a clear strobe per bit. There is also a one-shot debug source. The mask bits are level-like: servicing leaves them set. The debug source is dropped at every decision, whether or not it was serviced.

The controller is a state machine with seven states. IDLE waits for a boundary. On an accepted boundary it moves to PUSH_HI for NMI or IRQ, to VEC_LO for reset, and to FINISH otherwise. PUSH_HI moves to PUSH_LO, then PUSH_P, then VEC_LO. VEC_LO moves to VEC_HI, VEC_HI moves to FINISH, and FINISH always returns to IDLE.

Top module: `irq_rst_seq`

## Requirements
- R1: After `rst_n` is released, `stall`, `done`, `mem_rd` and `mem_wr` are low, and a reset request is pending.
- R2: A reset is serviced in this order: read 0xFFFC (low byte), read 0xFFFD (high byte), then a FINISH cycle. FINISH drives `pc_load` with the fetched vector, `p_load` with 0x04 (only the I flag, bit 2), and `jam_clr`. It drives no `sp_load` and no `cyc_valid`. The reset request is cleared; `rst_req_set` sets it again.
- R3: Only one event is handled per boundary, in fixed priority: reset, then late NMI, then NMI, then IRQ.
- R4: A pending late NMI is only turned into a pending NMI at the boundary that picks it. That boundary has no bus cycle and finishes at once. The NMI is serviced at a later boundary.
- R5: An interrupt writes three bytes in order: PC high, PC low, then status. Each write goes to 0x0100 + SP, and SP then decrements with 8-bit wrap. The status byte has B (bit 4) cleared and U (bit 5) set. `sp_out` is the entry SP minus 3.
- R6: An NMI fetches its vector from 0xFFFA/0xFFFB. It reports `p_out` = entry status with I (bit 2) set, and `cyc_add` = 7 with `cyc_valid`. It clears the NMI request.
- R7: While `jammed` is high, a pending NMI produces no bus cycles and stays pending. Lower-priority IRQs are not considered at that boundary.
- R8: An IRQ is taken only when a mask bit or the debug source is pending, `i_prev` is 0 and `jammed` is 0. It uses the R5 push sequence, vector 0xFFFE/0xFFFF, and the R6 status and cycle rules.
- R9: Servicing leaves the mask bits set. `irq_clr[n]` clears bit n. If `irq_set[n]` and `irq_clr[n]` arrive in the same cycle, the bit ends up set.
- R10: The debug source is cleared at every accepted boundary, whether or not an IRQ was taken.
- R11: `stall` is high from the cycle after the accepting boundary through the single `done` cycle. `done` comes 1 cycle after the boundary for no event, 3 cycles after for reset, and 6 cycles after for an interrupt. `bnd_req` is ignored while `stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bnd_req | input | 1 | Core is at an instruction boundary |
| rst_req_set | input | 1 | Sets the reset request |
| nmi_set | input | 1 | Sets the NMI request |
| nmi_late_set | input | 1 | Sets the late-NMI request |
| dbg_irq_set | input | 1 | Sets the one-shot debug interrupt source |
| irq_set | input | IRQ_W | Per-bit set strobes for the IRQ mask |
| irq_clr | input | IRQ_W | Per-bit clear strobes for the IRQ mask |
| i_prev | input | 1 | I flag as sampled before the previous instruction |
| jammed | input | 1 | Core is halted |
| pc_in | input | 16 | Current PC |
| sp_in | input | 8 | Current SP |
| p_in | input | 8 | Current status register |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_rd` |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| stall | output | 1 | Hold the core's fetch stage |
| done | output | 1 | Sequence complete (one cycle) |
| pc_load | output | 1 | Load `pc_out` into PC |
| pc_out | output | 16 | New PC |
| sp_load | output | 1 | Load `sp_out` into SP |
| sp_out | output | 8 | New SP |
| p_load | output | 1 | Load `p_out` into status |
| p_out | output | 8 | New status |
| jam_clr | output | 1 | Clear the core's jammed state |
| cyc_valid | output | 1 | `cyc_add` is valid |
| cyc_add | output | CYC_W | Cycle-count increment |

## Verification
A boundary presented in cycle k is registered at the next edge. The first bus cycle is therefore visible in cycle k+1. `done` falls in cycle k+1 for a plain boundary, k+3 for reset, and k+6 for an interrupt. When the bench raises `bnd_req`, its reference model appends one expected record per cycle, starting with an idle record for cycle k itself. At every falling edge it pops one record and compares it with the ports, so any bus cycle or load that lands one cycle early or late shows up as a mismatch. Strobes are applied in cycles before the boundary, so the model's pending state is always the state the decision sees.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_P,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_RESET,
        EV_LATE,
        EV_NMI,
        EV_IRQ
    } seq_event_t;

    localparam logic [15:0] VEC_NMI    = 16'hFFFA;
    localparam logic [15:0] VEC_RST    = 16'hFFFC;
    localparam logic [15:0] VEC_IRQ    = 16'hFFFE;
    localparam logic [7:0]  STACK_PAGE = 8'h01;
    localparam int          FLAG_I     = 2;
    localparam int          FLAG_B     = 4;
    localparam int          FLAG_U     = 5;

endpackage

// File: rtl/seq_pend.sv
module seq_pend #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req_set,
    input  logic             nmi_set,
    input  logic             nmi_late_set,
    input  logic             dbg_irq_set,
    input  logic [IRQ_W-1:0] irq_set,
    input  logic [IRQ_W-1:0] irq_clr,
    input  logic             clr_reset,
    input  logic             late_to_nmi,
    input  logic             clr_nmi,
    input  logic             clr_dbg,
    output logic             rst_pend,
    output logic             late_pend,
    output logic             nmi_pend,
    output logic             dbg_pend,
    output logic [IRQ_W-1:0] irq_pend
);

    // reset is pending out of power-up
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            rst_pend <= 1'b1;
        else if (rst_req_set)  rst_pend <= 1'b1;
        else if (clr_reset)    rst_pend <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            late_pend <= 1'b0;
        else if (nmi_late_set) late_pend <= 1'b1;
        else if (late_to_nmi)  late_pend <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      nmi_pend <= 1'b0;
        else if (nmi_set || late_to_nmi) nmi_pend <= 1'b1;
        else if (clr_nmi)                nmi_pend <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           dbg_pend <= 1'b0;
        else if (dbg_irq_set) dbg_pend <= 1'b1;
        else if (clr_dbg)     dbg_pend <= 1'b0;
    end

    for (genvar g = 0; g < IRQ_W; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          irq_pend[g] <= 1'b0;
            else if (irq_set[g]) irq_pend[g] <= 1'b1;
            else if (irq_clr[g]) irq_pend[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/seq_arb.sv
module seq_arb
    import seq_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic             rst_pend,
    input  logic             late_pend,
    input  logic             nmi_pend,
    input  logic             dbg_pend,
    input  logic [IRQ_W-1:0] irq_pend,
    input  logic             i_prev,
    input  logic             jammed,
    output seq_event_t       ev
);

    logic any_irq;
    assign any_irq = (|irq_pend) || dbg_pend;

    always_comb begin
        ev = EV_NONE;
        if (rst_pend)
            ev = EV_RESET;
        else if (late_pend)
            ev = EV_LATE;
        else if (nmi_pend)
            ev = jammed ? EV_NONE : EV_NMI;
        else if (any_irq && !i_prev && !jammed)
            ev = EV_IRQ;
    end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
#(
    parameter int CYC_W      = 4,
    parameter int SVC_CYCLES = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd_req,
    input  seq_event_t       ev,
    input  logic [15:0]      pc_in,
    input  logic [7:0]       sp_in,
    input  logic [7:0]       p_in,
    input  logic [7:0]       mem_rdata,
    output logic             accept,
    output logic [15:0]      mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [7:0]       mem_wdata,
    output logic             stall,
    output logic             done,
    output logic             pc_load,
    output logic [15:0]      pc_out,
    output logic             sp_load,
    output logic [7:0]       sp_out,
    output logic             p_load,
    output logic [7:0]       p_out,
    output logic             jam_clr,
    output logic             cyc_valid,
    output logic [CYC_W-1:0] cyc_add
);

    seq_state_t state, nxt;
    seq_event_t kind;
    logic [15:0] pc_q;
    logic [7:0]  sp_q, p_q, vec_lo, vec_hi;
    logic [15:0] vec_base;
    logic        is_int;

    assign accept = (state == ST_IDLE) && bnd_req;
    assign is_int = (kind == EV_NMI) || (kind == EV_IRQ);

    always_comb begin
        unique case (kind)
            EV_RESET: vec_base = VEC_RST;
            EV_NMI:   vec_base = VEC_NMI;
            default:  vec_base = VEC_IRQ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (bnd_req) begin
                    if (ev == EV_NMI || ev == EV_IRQ) nxt = ST_PUSH_HI;
                    else if (ev == EV_RESET)          nxt = ST_VEC_LO;
                    else                              nxt = ST_FINISH;
                end
            end
            ST_PUSH_HI: nxt = ST_PUSH_LO;
            ST_PUSH_LO: nxt = ST_PUSH_P;
            ST_PUSH_P:  nxt = ST_VEC_LO;
            ST_VEC_LO:  nxt = ST_VEC_HI;
            ST_VEC_HI:  nxt = ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // captured context and fetched vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind   <= EV_NONE;
            pc_q   <= '0;
            sp_q   <= '0;
            p_q    <= '0;
            vec_lo <= '0;
            vec_hi <= '0;
        end else begin
            if (accept) begin
                kind <= ev;
                pc_q <= pc_in;
                sp_q <= sp_in;
                p_q  <= p_in;
            end
            if (state == ST_PUSH_HI || state == ST_PUSH_LO || state == ST_PUSH_P)
                sp_q <= sp_q - 8'd1;
            if (state == ST_VEC_LO) vec_lo <= mem_rdata;
            if (state == ST_VEC_HI) vec_hi <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        done      = 1'b0;
        pc_load   = 1'b0;
        sp_load   = 1'b0;
        p_load    = 1'b0;
        p_out     = '0;
        jam_clr   = 1'b0;
        cyc_valid = 1'b0;
        cyc_add   = '0;
        stall     = (state != ST_IDLE);
        pc_out    = {vec_hi, vec_lo};
        sp_out    = sp_q;
        unique case (state)
            ST_IDLE: ;
            ST_PUSH_HI: begin
                mem_wr    = 1'b1;
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = pc_q[15:8];
            end
            ST_PUSH_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = pc_q[7:0];
            end
            ST_PUSH_P: begin
                mem_wr    = 1'b1;
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = p_q;
                mem_wdata[FLAG_B] = 1'b0;
                mem_wdata[FLAG_U] = 1'b1;
            end
            ST_VEC_LO: begin
                mem_rd   = 1'b1;
                mem_addr = vec_base;
            end
            ST_VEC_HI: begin
                mem_rd   = 1'b1;
                mem_addr = vec_base | 16'h0001;
            end
            ST_FINISH: begin
                done = 1'b1;
                if (kind == EV_RESET) begin
                    pc_load = 1'b1;
                    p_load  = 1'b1;
                    p_out   = 8'h00;
                    p_out[FLAG_I] = 1'b1;
                    jam_clr = 1'b1;
                end else if (is_int) begin
                    pc_load   = 1'b1;
                    sp_load   = 1'b1;
                    p_load    = 1'b1;
                    p_out     = p_q;
                    p_out[FLAG_I] = 1'b1;
                    cyc_valid = 1'b1;
                    cyc_add   = CYC_W'(SVC_CYCLES);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_rst_seq.sv
module irq_rst_seq
    import seq_pkg::*;
#(
    parameter int IRQ_W      = 4,
    parameter int CYC_W      = 4,
    parameter int SVC_CYCLES = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd_req,
    input  logic             rst_req_set,
    input  logic             nmi_set,
    input  logic             nmi_late_set,
    input  logic             dbg_irq_set,
    input  logic [IRQ_W-1:0] irq_set,
    input  logic [IRQ_W-1:0] irq_clr,
    input  logic             i_prev,
    input  logic             jammed,
    input  logic [15:0]      pc_in,
    input  logic [7:0]       sp_in,
    input  logic [7:0]       p_in,
    input  logic [7:0]       mem_rdata,
    output logic [15:0]      mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [7:0]       mem_wdata,
    output logic             stall,
    output logic             done,
    output logic             pc_load,
    output logic [15:0]      pc_out,
    output logic             sp_load,
    output logic [7:0]       sp_out,
    output logic             p_load,
    output logic [7:0]       p_out,
    output logic             jam_clr,
    output logic             cyc_valid,
    output logic [CYC_W-1:0] cyc_add
);

    logic             rst_pend, late_pend, nmi_pend, dbg_pend;
    logic [IRQ_W-1:0] irq_pend;
    seq_event_t       ev;
    logic             accept;

    seq_pend #(.IRQ_W(IRQ_W)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_req_set (rst_req_set),
        .nmi_set     (nmi_set),
        .nmi_late_set(nmi_late_set),
        .dbg_irq_set (dbg_irq_set),
        .irq_set     (irq_set),
        .irq_clr     (irq_clr),
        .clr_reset   (accept && ev == EV_RESET),
        .late_to_nmi (accept && ev == EV_LATE),
        .clr_nmi     (accept && ev == EV_NMI),
        .clr_dbg     (accept),
        .rst_pend    (rst_pend),
        .late_pend   (late_pend),
        .nmi_pend    (nmi_pend),
        .dbg_pend    (dbg_pend),
        .irq_pend    (irq_pend)
    );

    seq_arb #(.IRQ_W(IRQ_W)) u_arb (
        .rst_pend (rst_pend),
        .late_pend(late_pend),
        .nmi_pend (nmi_pend),
        .dbg_pend (dbg_pend),
        .irq_pend (irq_pend),
        .i_prev   (i_prev),
        .jammed   (jammed),
        .ev       (ev)
    );

    seq_fsm #(.CYC_W(CYC_W), .SVC_CYCLES(SVC_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bnd_req  (bnd_req),
        .ev       (ev),
        .pc_in    (pc_in),
        .sp_in    (sp_in),
        .p_in     (p_in),
        .mem_rdata(mem_rdata),
        .accept   (accept),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_wdata(mem_wdata),
        .stall    (stall),
        .done     (done),
        .pc_load  (pc_load),
        .pc_out   (pc_out),
        .sp_load  (sp_load),
        .sp_out   (sp_out),
        .p_load   (p_load),
        .p_out    (p_out),
        .jam_clr  (jam_clr),
        .cyc_valid(cyc_valid),
        .cyc_add  (cyc_add)
    );

endmodule

// File: rtl/irq_rst_seq_chk.sv
module irq_rst_seq_chk #(
    parameter int CYC_W      = 4,
    parameter int SVC_CYCLES = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      mem_addr,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             stall,
    input logic             done,
    input logic             pc_load,
    input logic             sp_load,
    input logic             p_load,
    input logic [7:0]       p_out,
    input logic             jam_clr,
    input logic             cyc_valid,
    input logic [CYC_W-1:0] cyc_add
);

    // R5
    push_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_addr[15:8] == 8'h01);

    // R5
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> mem_addr[7:0] == $past(mem_addr[7:0]) - 8'd1);

    // R8
    vec_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr >= 16'hFFFA && !mem_wr));

    // R2
    reset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jam_clr |-> (pc_load && p_load && p_out == 8'h04 && !sp_load && !cyc_valid));

    // R6
    svc_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_add == CYC_W'(SVC_CYCLES) && sp_load && p_out[2]));

    // R11
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!stall && !done));

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !done) |=> stall);

    // R11
    load_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load || sp_load || p_load) |-> (done && stall));

endmodule

bind irq_rst_seq irq_rst_seq_chk #(.CYC_W(CYC_W), .SVC_CYCLES(SVC_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .stall    (stall),
    .done     (done),
    .pc_load  (pc_load),
    .sp_load  (sp_load),
    .p_load   (p_load),
    .p_out    (p_out),
    .jam_clr  (jam_clr),
    .cyc_valid(cyc_valid),
    .cyc_add  (cyc_add)
);

// File: tb/sim_irq_rst_seq.sv
module sim_irq_rst_seq;
    localparam int IRQ_W = 4;
    localparam int CYC_W = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, bnd_req, rst_req_set, nmi_set, nmi_late_set, dbg_irq_set;
    logic [IRQ_W-1:0] irq_set, irq_clr;
    logic i_prev, jammed;
    logic [15:0] pc_in;
    logic [7:0]  sp_in, p_in, mem_rdata;
    logic [15:0] mem_addr, pc_out;
    logic mem_rd, mem_wr, stall, done, pc_load, sp_load, p_load, jam_clr, cyc_valid;
    logic [7:0] mem_wdata, sp_out, p_out;
    logic [CYC_W-1:0] cyc_add;

    irq_rst_seq #(.IRQ_W(IRQ_W), .CYC_W(CYC_W)) u0 (.*);

    // vector bytes at 0xFFFA..0xFFFF
    logic [7:0] vb [0:5];
    always_comb begin
        if (mem_addr >= 16'hFFFA) mem_rdata = vb[3'(mem_addr[2:0] - 3'd2)];
        else                      mem_rdata = 8'hEE;
    end

    typedef struct {
        bit stall, done, rd, wr;
        logic [15:0] addr;
        logic [7:0]  wdata;
        bit pcl; logic [15:0] pc;
        bit spl; logic [7:0] sp;
        bit pl;  logic [7:0] p;
        bit jc, cv; logic [3:0] cyc;
        string tag;
    } rec_t;

    rec_t expq[$];
    int n_chk = 0, n_fail = 0;
    bit chk_on = 0;
    bit m_rst, m_late, m_nmi, m_dbg;
    bit [IRQ_W-1:0] m_irq;

    function automatic rec_t blank(string t);
        rec_t r;
        r.stall = 0; r.done = 0; r.rd = 0; r.wr = 0; r.addr = 0; r.wdata = 0;
        r.pcl = 0; r.pc = 0; r.spl = 0; r.sp = 0; r.pl = 0; r.p = 0;
        r.jc = 0; r.cv = 0; r.cyc = 0; r.tag = t;
        return r;
    endfunction

    function automatic logic [68:0] norm(rec_t r);
        return {r.stall, r.done, r.rd, r.wr,
                (r.rd || r.wr) ? r.addr : 16'h0, r.wr ? r.wdata : 8'h0,
                r.pcl, r.pcl ? r.pc : 16'h0, r.spl, r.spl ? r.sp : 8'h0,
                r.pl, r.pl ? r.p : 8'h0, r.jc, r.cv, r.cv ? r.cyc : 4'h0};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            rec_t e, a;
            e = (expq.size() != 0) ? expq.pop_front() : blank("R11");
            a = blank("");
            a.stall = stall; a.done = done; a.rd = mem_rd; a.wr = mem_wr;
            a.addr = mem_addr; a.wdata = mem_wdata;
            a.pcl = pc_load; a.pc = pc_out; a.spl = sp_load; a.sp = sp_out;
            a.pl = p_load; a.p = p_out; a.jc = jam_clr; a.cv = cyc_valid; a.cyc = cyc_add;
            n_chk++;
            if (norm(a) !== norm(e)) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", e.tag, norm(a), norm(e));
            end
        end
    end

    task automatic push_finish(string t);
        rec_t r = blank(t);
        r.stall = 1; r.done = 1;
        expq.push_back(r);
    endtask

    task automatic model_service(logic [15:0] base, string t);
        rec_t r;
        logic [7:0] sp = sp_in;
        logic [7:0] bytes [3];
        bytes[0] = pc_in[15:8]; bytes[1] = pc_in[7:0];
        bytes[2] = (p_in & 8'hEF) | 8'h20;
        for (int i = 0; i < 3; i++) begin
            r = blank(t); r.stall = 1; r.wr = 1;
            r.addr = {8'h01, sp}; r.wdata = bytes[i];
            expq.push_back(r);
            sp = sp - 8'd1;
        end
        for (int i = 0; i < 2; i++) begin
            r = blank(t); r.stall = 1; r.rd = 1; r.addr = base + 16'(i);
            expq.push_back(r);
        end
        r = blank(t); r.stall = 1; r.done = 1;
        r.pcl = 1; r.pc = {vb[base[2:0] - 3'd1], vb[base[2:0] - 3'd2]};
        r.spl = 1; r.sp = sp; r.pl = 1; r.p = p_in | 8'h04;
        r.cv = 1; r.cyc = 4'd7;
        expq.push_back(r);
    endtask

    task automatic model_decide(string t);
        rec_t r;
        expq.push_back(blank(t));
        if (m_rst) begin
            m_rst = 0;
            for (int i = 0; i < 2; i++) begin
                r = blank(t); r.stall = 1; r.rd = 1; r.addr = 16'hFFFC + 16'(i);
                expq.push_back(r);
            end
            r = blank(t); r.stall = 1; r.done = 1; r.pcl = 1; r.pc = {vb[3], vb[2]};
            r.pl = 1; r.p = 8'h04; r.jc = 1;
            expq.push_back(r);
        end else if (m_late) begin
            m_late = 0; m_nmi = 1;
            push_finish(t);
        end else if (m_nmi) begin
            if (!jammed) begin
                m_nmi = 0;
                model_service(16'hFFFA, t);
            end else push_finish(t);
        end else if (((|m_irq) || m_dbg) && !i_prev && !jammed) begin
            model_service(16'hFFFE, t);
        end else push_finish(t);
        m_dbg = 0;
    endtask

    task automatic boundary(string t, bit poke);
        @(posedge clk); #1;
        bnd_req = 1;
        model_decide(t);
        @(posedge clk); #1;
        bnd_req = 0;
        if (poke) begin
            @(posedge clk); #1; bnd_req = 1;
            @(posedge clk); #1; bnd_req = 0;
        end
        while (expq.size() != 0) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic strobe(bit rs, bit ns, bit ls, bit ds,
                          logic [IRQ_W-1:0] is, logic [IRQ_W-1:0] ic);
        @(posedge clk); #1;
        rst_req_set = rs; nmi_set = ns; nmi_late_set = ls; dbg_irq_set = ds;
        irq_set = is; irq_clr = ic;
        if (rs) m_rst = 1;
        if (ns) m_nmi = 1;
        if (ls) m_late = 1;
        if (ds) m_dbg = 1;
        m_irq = (m_irq & ~ic) | is;
        @(posedge clk); #1;
        rst_req_set = 0; nmi_set = 0; nmi_late_set = 0; dbg_irq_set = 0;
        irq_set = '0; irq_clr = '0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; bnd_req = 0; rst_req_set = 0; nmi_set = 0; nmi_late_set = 0;
        dbg_irq_set = 0; irq_set = '0; irq_clr = '0; i_prev = 0; jammed = 0;
        pc_in = 16'h8123; sp_in = 8'hFD; p_in = 8'hD1;
        vb[0] = 8'h5A; vb[1] = 8'h90; vb[2] = 8'h00; vb[3] = 8'hC0; vb[4] = 8'h34; vb[5] = 8'hE1;
        m_rst = 1; m_late = 0; m_nmi = 0; m_dbg = 0; m_irq = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!stall, "R1", 32'(stall), 0);
        chk(!done, "R1", 32'(done), 0);
        chk(!mem_rd && !mem_wr, "R1", 32'({mem_rd, mem_wr}), 0);
        chk_on = 1;

        // R3 priority: reset beats NMI beats IRQ
        strobe(0, 1, 0, 0, 4'b0001, 4'b0000);
        boundary("R2", 0);
        boundary("R3", 0);
        boundary("R8", 0);

        // R9 level-held sources
        boundary("R9", 0);
        strobe(0, 0, 0, 0, 4'b0000, 4'b0001);
        boundary("R9", 0);
        strobe(0, 0, 0, 0, 4'b0100, 4'b0100);
        boundary("R9", 0);
        strobe(0, 0, 0, 0, 4'b0000, 4'b0100);

        // R4 late NMI, then R6 NMI service
        strobe(0, 0, 1, 0, 4'b0010, 4'b0000);
        boundary("R4", 0);
        pc_in = 16'h4567; p_in = 8'h30;
        boundary("R6", 0);
        boundary("R3", 0);
        strobe(0, 0, 0, 0, 4'b0000, 4'b0010);

        // R7 jammed NMI stays pending and blocks IRQ
        jammed = 1;
        strobe(0, 1, 0, 0, 4'b1000, 4'b0000);
        boundary("R7", 0);
        jammed = 0;
        boundary("R7", 0);
        jammed = 1;
        boundary("R8", 0);
        jammed = 0;
        strobe(0, 0, 0, 0, 4'b0000, 4'b1000);

        // R8 masking by i_prev
        strobe(0, 0, 0, 0, 4'b0001, 4'b0000);
        i_prev = 1;
        boundary("R8", 0);
        i_prev = 0;
        boundary("R8", 0);
        strobe(0, 0, 0, 0, 4'b0000, 4'b0001);

        // R10 one-shot debug source
        i_prev = 1;
        strobe(0, 0, 0, 1, 4'b0000, 4'b0000);
        boundary("R10", 0);
        i_prev = 0;
        boundary("R10", 0);
        strobe(0, 0, 0, 1, 4'b0000, 4'b0000);
        boundary("R10", 0);
        boundary("R10", 0);

        // R11 boundary during a running sequence is ignored
        strobe(0, 1, 0, 0, 4'b0000, 4'b0000);
        boundary("R11", 1);

        // R5 stack pointer wraps
        sp_in = 8'h01; p_in = 8'h00; pc_in = 16'hABCD;
        vb[0] = 8'h77; vb[1] = 8'h66;
        strobe(0, 1, 0, 0, 4'b0000, 4'b0000);
        boundary("R5", 0);

        // R2 requested reset beats NMI and clears jam
        vb[2] = 8'h21; vb[3] = 8'hF0;
        jammed = 1;
        strobe(1, 1, 0, 0, 4'b0000, 4'b0000);
        boundary("R2", 0);
        jammed = 0;
        boundary("R3", 0);
        boundary("R2", 0);

        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule